// File: doc/BRIEF.md
# Serial Window Address Uploader

This block sits on the host side of an image sensor. It sends the start corner of a region of interest, a 10-bit row address and a 6-bit column address, over a three-wire link: a serial clock, a serial data line and a load strobe. On the sensor side the link feeds a 16-cell shift register. The register clocks data in on each rising edge of the serial clock. On the rising edge of the load strobe, its parallel outputs are copied into the sensor's address registers.

A one-cycle `start` pulse latches both addresses. The block then produces 16 serial clock periods. Data changes only while the serial clock is low. After the last falling edge it waits half a serial period and then raises the load strobe for one full serial period. `busy` covers the whole transfer. The serial half period is a parameter in system clock cycles, so a 200 MHz system clock with the default of 5 gives a 20 MHz link.

Top module: `win_addr_loader`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `ser_clk`, `ser_data`, `ser_load` and `busy` are all 0.
- R2: A `start` pulse seen while `busy` is low latches `row_addr` and `col_addr`, and `busy` is 1 in the next cycle. Changes on the address inputs after that cycle do not alter the frame being sent.
- R3: Each frame has exactly 16 rising edges of `ser_clk`. Each high phase and each low phase of a data period lasts HALF_DIV system cycles, and the clock starts low.
- R4: `ser_data` never changes while `ser_clk` is high, and does not change in the cycle where `ser_clk` rises.
- R5: The bit sampled at rising edge k (k = 0..15) is bit k of the word {col_addr, row_addr}. The row is therefore sent first, least significant bit first, and column bit 5 is sent last.
- R6: `ser_load` rises exactly HALF_DIV cycles after the 16th falling edge of `ser_clk` and stays high for 2*HALF_DIV cycles. `ser_clk` is low throughout.
- R7: `busy` stays high for exactly 35*HALF_DIV cycles and falls in the same cycle as `ser_load`.
- R8: A `start` pulse while `busy` is high is ignored: the frame in flight is unchanged.
- R9: A `start` pulse in the last busy cycle is ignored. A `start` pulse in the first idle cycle after it begins a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| row_addr | input | 10 | Window start row (Y) |
| col_addr | input | 6 | Window start column (X) |
| busy | output | 1 | Transfer in progress |
| ser_clk | output | 1 | Serial clock to sensor, idles low |
| ser_data | output | 1 | Serial data to sensor |
| ser_load | output | 1 | Load strobe to sensor |

## Verification
The end of a frame and a new `start` request can land in the same cycle. The final half-period tick clears `busy` at the same edge where a pending `start` would be judged. The bench pulses `start` with unrelated addresses in the last busy cycle and expects `busy` low in the next cycle, with no extra frame. In other runs it pulses `start` in the first idle cycle and expects a full, correct second frame straight after the first, received by a behavioural shift-register model of the sensor.

// File: rtl/win_addr_pkg.sv
// Package: shared constants, types and helpers for the window address uploader.
// Assumes the sensor frame layout is fixed: 10 row bits then 6 column bits.
package win_addr_pkg;
    localparam int ROW_W   = 10;
    localparam int COL_W   = 6;
    localparam int FRAME_W = ROW_W + COL_W;
    // Half periods: two per data bit, one quiet low half, two for the strobe.
    localparam int DATA_HP = 2 * FRAME_W;
    localparam int LAST_HP = DATA_HP + 2;
    localparam int HP_W    = $clog2(LAST_HP + 1);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [HP_W-1:0]    hp_t;

    // Builds the shift word so that bit 0 leaves first (row LSB first, column MSB last).
    function automatic frame_t pack_frame(input logic [ROW_W-1:0] row,
                                          input logic [COL_W-1:0] col);
        return {col, row};
    endfunction
endpackage

// File: rtl/wal_tick_gen.sv
// Module: divides the system clock into serial half-period ticks.
// Assumes HALF_DIV >= 1; the counter is held at zero while not running,
// so the first tick comes HALF_DIV cycles after run goes high.
module wal_tick_gen #(
    parameter int HALF_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_MAX);

    // Counts system cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wal_sequencer.sv
// Module: tracks the half-period index of a transfer and the busy flag.
// Assumes start is ignored while busy; exposes next-state values so the
// output stage can register its pins in step with the sequence.
module wal_sequencer
    import win_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic launch,
    output logic busy,
    output logic busy_nxt,
    output hp_t  hp_nxt
);
    hp_t hp_q;

    assign launch = start && !busy;

    // Computes the next busy flag and half-period index.
    always_comb begin
        busy_nxt = busy;
        hp_nxt   = hp_q;
        if (launch) begin
            busy_nxt = 1'b1;
            hp_nxt   = '0;
        end else if (busy && tick) begin
            if (hp_q == hp_t'(LAST_HP)) begin
                busy_nxt = 1'b0;
                hp_nxt   = '0;
            end else begin
                hp_nxt = hp_q + 1'b1;
            end
        end
    end

    // Holds the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            hp_q <= '0;
        end else begin
            busy <= busy_nxt;
            hp_q <= hp_nxt;
        end
    end
endmodule

// File: rtl/wal_serializer.sv
// Module: holds the latched frame and drives the three registered link pins.
// Assumes odd half-period indices below DATA_HP are the clock-high phases;
// data therefore only moves when the clock drops.
module wal_serializer
    import win_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [COL_W-1:0]  col_addr,
    input  logic              busy_nxt,
    input  hp_t               hp_nxt,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_load
);
    frame_t frame_q;
    frame_t frame_src;
    logic   in_data;
    logic   clk_d, data_d, load_d;

    assign frame_src = launch ? pack_frame(row_addr, col_addr) : frame_q;
    assign in_data   = busy_nxt && (hp_nxt < hp_t'(DATA_HP));

    // Decodes the pin values for the coming half period.
    always_comb begin
        clk_d  = in_data && hp_nxt[0];
        data_d = in_data ? frame_src[hp_nxt[HP_W-1:1]] : 1'b0;
        load_d = busy_nxt && (hp_nxt > hp_t'(DATA_HP));
    end

    // Captures the addresses when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (launch) begin
            frame_q <= frame_src;
        end
    end

    // Registers the link pins so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
            ser_load <= 1'b0;
        end else begin
            ser_clk  <= clk_d;
            ser_data <= data_d;
            ser_load <= load_d;
        end
    end
endmodule

// File: rtl/win_addr_loader.sv
// Module: top of the serial window address uploader.
// Sends a row/column start address as a 16-bit serial frame, then pulses
// the load strobe. Assumes one transfer at a time; HALF_DIV sets the
// serial half period in system clock cycles.
module win_addr_loader
    import win_addr_pkg::*;
#(
    parameter int HALF_DIV = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [COL_W-1:0] col_addr,
    output logic             busy,
    output logic             ser_clk,
    output logic             ser_data,
    output logic             ser_load
);
    logic tick;
    logic launch;
    logic busy_nxt;
    hp_t  hp_nxt;

    wal_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    wal_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .launch   (launch),
        .busy     (busy),
        .busy_nxt (busy_nxt),
        .hp_nxt   (hp_nxt)
    );

    wal_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .row_addr (row_addr),
        .col_addr (col_addr),
        .busy_nxt (busy_nxt),
        .hp_nxt   (hp_nxt),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .ser_load (ser_load)
    );
endmodule

// File: rtl/wal_checker.sv
// Module: protocol checker bound to the uploader; watches only its ports.
// Assumes HALF_DIV matches the bound instance.
module wal_checker #(
    parameter int HALF_DIV = 5
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_load
);
    int unsigned hi_cnt;
    int unsigned ld_cnt;

    // Counts consecutive high cycles of the serial clock and of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            ld_cnt <= 0;
        end else begin
            hi_cnt <= ser_clk  ? hi_cnt + 1 : 0;
            ld_cnt <= ser_load ? ld_cnt + 1 : 0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_data && !ser_load));

    a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r3_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_cnt == HALF_DIV));

    a_r4_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> !ser_clk);

    a_r6_strobe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> (!ser_clk && busy));

    a_r6_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_load) |-> (ld_cnt == 2 * HALF_DIV));

    a_r7_busy_ends_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(ser_load));
endmodule

bind win_addr_loader wal_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_load (ser_load)
);

// File: tb/sim_win_addr_loader.sv
`timescale 1ns/1ps
module sim_win_addr_loader;
    localparam int HD        = 5;
    localparam int FRAME_CYC = 35 * HD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] row = '0;
    logic [5:0] col = '0;
    logic       busy, ser_clk, ser_data, ser_load;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    win_addr_loader #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row), .col_addr(col),
        .busy(busy), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load)
    );

    function automatic logic [15:0] ref_frame(input logic [9:0] r, input logic [5:0] c);
        return {c, r};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called with start already driven at the current negedge.
    task automatic track(input logic [15:0] exp, input bit inj_mid, input bit inj_last,
                         input bit chain, input logic [9:0] nrow, input logic [5:0] ncol);
        int cyc = 0;
        bit pclk = 0, pdat = 0, pload = 0;
        int bits = 0, hi_len = 0, bad_hi = 0, hi_chg = 0;
        int last_fall = -1, load_rise = -1, load_len = 0, load_clk = 0;
        logic [15:0] rx = '0;
        logic [15:0] latched = '0;
        @(negedge clk);
        start = 1'b0;
        row = 10'($urandom);
        col = 6'($urandom);
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        while (busy && cyc < 40 * HD) begin
            cyc++;
            if (ser_clk && !pclk) begin
                rx = {ser_data, rx[15:1]};
                bits++;
            end
            if (ser_clk && pclk && (ser_data != pdat)) hi_chg++;
            if (ser_clk) hi_len++;
            if (!ser_clk && pclk) begin
                if (hi_len != HD) bad_hi++;
                hi_len = 0;
                last_fall = cyc;
            end
            if (ser_load && !pload) begin
                load_rise = cyc;
                latched = rx;
            end
            if (ser_load) begin
                load_len++;
                if (ser_clk) load_clk++;
            end
            pclk = ser_clk; pdat = ser_data; pload = ser_load;
            if (inj_mid && cyc == 7 * HD + 2) begin
                start = 1'b1; row = 10'($urandom); col = 6'($urandom);
            end else if (inj_last && cyc == FRAME_CYC) begin
                start = 1'b1; row = ~exp[9:0]; col = ~exp[15:10];
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        chk(cyc == FRAME_CYC && !busy, inj_last ? "R7/R9" : "R7", "busy length", cyc, FRAME_CYC);
        chk(bits == 16 && bad_hi == 0, "R3", "rising edges / bad high phases", bits * 256 + bad_hi, 16 * 256);
        chk(hi_chg == 0, "R4", "data changes while clock high", hi_chg, 0);
        chk(latched == exp, inj_mid ? "R5/R8" : "R5", "received frame", int'(latched), int'(exp));
        chk(load_rise == last_fall + HD, "R6", "strobe rise cycle", load_rise, last_fall + HD);
        chk(load_len == 2 * HD && load_clk == 0, "R6", "strobe length", load_len, 2 * HD);
        chk(!ser_clk && !ser_data && !ser_load, "R1", "idle pins", {ser_clk, ser_data, ser_load}, 0);
        if (chain) begin
            start = 1'b1; row = nrow; col = ncol;
        end else begin
            start = 1'b0;
        end
    endtask

    task automatic launch(input logic [9:0] r, input logic [5:0] c);
        @(negedge clk);
        start = 1'b1; row = r; col = c;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (4) @(negedge clk);
        chk({busy, ser_clk, ser_data, ser_load} == 4'b0, "R1", "reset pins",
            {busy, ser_clk, ser_data, ser_load}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, ser_clk, ser_data, ser_load} == 4'b0, "R1", "idle after reset",
            {busy, ser_clk, ser_data, ser_load}, 0);

        // Directed corner frames.
        launch(10'h000, 6'h00); track(ref_frame(10'h000, 6'h00), 0, 0, 0, '0, '0);
        launch(10'h3FF, 6'h3F); track(ref_frame(10'h3FF, 6'h3F), 0, 0, 0, '0, '0);
        launch(10'h001, 6'h20); track(ref_frame(10'h001, 6'h20), 0, 0, 0, '0, '0);
        launch(10'h2AA, 6'h15); track(ref_frame(10'h2AA, 6'h15), 1, 0, 0, '0, '0);
        // R9: start in last busy cycle ignored, then chained start in first idle cycle.
        launch(10'h155, 6'h2A); track(ref_frame(10'h155, 6'h2A), 0, 1, 1, 10'h200, 6'h01);
        track(ref_frame(10'h200, 6'h01), 0, 0, 0, '0, '0);

        // Random frames with random injections.
        for (int i = 0; i < 24; i++) begin
            logic [9:0] r = 10'($urandom);
            logic [5:0] c = 6'($urandom);
            bit mid = 1'($urandom);
            bit lst = 1'($urandom);
            launch(r, c);
            track(ref_frame(r, c), mid, lst, 0, '0, '0);
        end

        repeat (3) @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule